// File: doc/BRIEF.md
# Plane-Masked Rectangle Raster Engine

This block owns a small 8-bit-per-pixel frame memory and redraws rectangles inside it. A host sends 32-bit command words one at a time through a single valid/ready port. Configuration words set the raster operation and the plane mask. A launch word picks the walk directions, and three coordinate words follow it: destination corner, size, source corner. The source word starts the engine. For every pixel of the rectangle it does one read-modify-write over a pair of cycles. Only the bits chosen by the plane mask are changed.

Overlapping screen-to-screen copies stay correct because each axis can be walked backwards. In a backward axis the host gives the source corner as the last pixel and the destination corner as one past the end. The engine steps the destination back by one before each access. A status word reports completion, and the host polls it. A solid fill in any colour takes two passes over the same rectangle: a set pass with mask `colour & planes`, then a clear pass with mask `~colour & planes`. A pass whose mask is zero is skipped. A registered read port returns any pixel of the frame memory.

Top module: `rect_rop_engine`

## Requirements
- R1: After reset, status bit 2 (done) reads 1, `cmd_ready` is 1 and every pixel of the frame memory is 0x00.
- R2: When no rectangle is pending, bits 31:28 of a word are its tag. Tag 0x1 latches the ROP code from bits 23:16, tag 0x2 latches the plane mask from bits 7:0, and tag 0x3 is a launch word. Any other tag is ignored. The three words after a launch word are taken as destination, size and source whatever their tag. Only the source word starts execution. Reset values are ROP 0x33 and mask 0xFF.
- R3: A coordinate word holds X in bits 15:0 and Y in bits 31:16, and a size word holds width in 15:0 and height in 31:16. Pixel (x,y) sits at read address y*FB_W + x, which is {y, x} for the default 16x16 frame.
- R4: ROP 0x00 clears the masked bits, 0x33 copies the masked bits from the source, 0xCC inverts the masked bits, and 0xFF sets them. Any other code leaves the destination unchanged.
- R5: Pixel bits outside the plane mask keep their old destination value. A two-pass fill builds an arbitrary colour within the mask.
- R6: In a forward axis, step i touches source start+i and destination start+i. Pixels are visited in row-major order, one per two cycles.
- R7: Launch-word bits 1 or 3 select backward Y, and bits 0 or 2 select backward X. In a backward axis, step i touches source S−i and destination D−1−i. A copy whose source lies above or left of an overlapping destination gives the same result as a copy from an unchanged snapshot.
- R8: Done drops to 0 in the cycle after a non-empty rectangle is launched, and rises to 1 in the cycle after its last pixel is written.
- R9: A rectangle with zero width or zero height changes no pixel, and done stays 1.
- R10: `cmd_ready` is 0 while a rectangle is being walked. A word presented then is not taken, so the ROP code and plane mask stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 32 | Command word |
| cmd_ready | output | 1 | Engine can take a word |
| status_word | output | 32 | Bit 2 = done, other bits 0 |
| rd_addr | input | AW | Pixel read address |
| rd_data | output | 8 | Pixel at rd_addr, one cycle later |

## Verification
The bench builds the block with the default 16x16 frame. With that size every pixel can be read back after each rectangle, and all four combinations of walk direction fit, with overlap, inside the frame. A 6x5 rectangle shifted by two pixels is enough to reveal a wrong pre-decrement or a wrong walk order. An 8x8 copy lasts 128 cycles, which leaves room to offer words while `cmd_ready` is low.

// File: rtl/rect_rop_pkg.sv
package rect_rop_pkg;
  localparam int PIX_W = 8;

  localparam logic [3:0] TAG_ROP    = 4'h1;
  localparam logic [3:0] TAG_MASK   = 4'h2;
  localparam logic [3:0] TAG_LAUNCH = 4'h3;

  localparam logic [7:0] OP_CLEAR = 8'h00;
  localparam logic [7:0] OP_COPY  = 8'h33;
  localparam logic [7:0] OP_INV   = 8'hCC;
  localparam logic [7:0] OP_SET   = 8'hFF;

  typedef enum logic [1:0] {W_IDLE, W_READ, W_WRITE} walk_state_t;

  // Result of one raster operation on one pixel.
  function automatic logic [PIX_W-1:0] rop_apply(input logic [7:0] code,
      input logic [PIX_W-1:0] mask, input logic [PIX_W-1:0] src,
      input logic [PIX_W-1:0] dst);
    logic [PIX_W-1:0] keep;
    keep = dst & ~mask;
    case (code)
      OP_CLEAR: rop_apply = keep;
      OP_COPY:  rop_apply = keep | (src & mask);
      OP_INV:   rop_apply = dst ^ mask;
      OP_SET:   rop_apply = dst | mask;
      default:  rop_apply = dst;
    endcase
  endfunction

  // Coordinate touched at step 'step' of one axis.
  function automatic logic [15:0] walk_coord(input logic [15:0] base,
      input logic [15:0] step, input logic back, input logic is_dst);
    if (!back) walk_coord = base + step;
    else       walk_coord = base - step - {15'd0, is_dst};
  endfunction
endpackage

// File: rtl/rop_cmd_decoder.sv
module rop_cmd_decoder
  import rect_rop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  input  logic        engine_busy,
  output logic        cmd_ready,
  output logic        launch,
  output logic [7:0]  rop_code,
  output logic [PIX_W-1:0] plane_mask,
  output logic        back_x,
  output logic        back_y,
  output logic [31:0] dst_xy,
  output logic [31:0] size_wh,
  output logic [31:0] src_xy
);
  logic [1:0] phase;
  logic       accept;

  assign cmd_ready = !engine_busy;
  assign accept    = cmd_valid && cmd_ready;
  assign launch    = accept && (phase == 2'd3);
  assign src_xy    = cmd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= 2'd0;
      rop_code   <= OP_COPY;
      plane_mask <= '1;
      back_x     <= 1'b0;
      back_y     <= 1'b0;
      dst_xy     <= '0;
      size_wh    <= '0;
    end else if (accept) begin
      case (phase)
        2'd0: begin
          case (cmd_word[31:28])
            TAG_ROP:  rop_code   <= cmd_word[23:16];
            TAG_MASK: plane_mask <= cmd_word[PIX_W-1:0];
            TAG_LAUNCH: begin
              back_y <= |(cmd_word[3:0] & 4'hA);
              back_x <= |(cmd_word[3:0] & 4'h5);
              phase  <= 2'd1;
            end
            default: ;
          endcase
        end
        2'd1: begin dst_xy  <= cmd_word; phase <= 2'd2; end
        2'd2: begin size_wh <= cmd_word; phase <= 2'd3; end
        default: phase <= 2'd0;
      endcase
    end
  end

  // R2: four words sit between launches, so launches are never adjacent.
  assert_launch_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
endmodule

// File: rtl/rop_walker.sv
module rop_walker
  import rect_rop_pkg::*;
#(
  parameter int FB_W = 16,
  parameter int FB_H = 16,
  localparam int XB = $clog2(FB_W),
  localparam int YB = $clog2(FB_H),
  localparam int AW = XB + YB
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          back_x,
  input  logic          back_y,
  input  logic [31:0]   dst_xy,
  input  logic [31:0]   size_wh,
  input  logic [31:0]   src_xy,
  output logic          busy,
  output logic          done,
  output logic          cap_en,
  output logic          wr_en,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  walk_state_t st;
  logic [15:0] sx, sy, dx, dy, w, h, cx, cy;
  logic        bx, by;
  logic [15:0] px_s, py_s, px_d, py_d;
  logic        zero_size, last_col, last_row;

  assign zero_size = (size_wh[15:0] == 16'd0) || (size_wh[31:16] == 16'd0);
  assign last_col  = (cx == w - 16'd1);
  assign last_row  = (cy == h - 16'd1);
  assign busy      = (st != W_IDLE);
  assign cap_en    = (st == W_READ);
  assign wr_en     = (st == W_WRITE);

  assign px_s = walk_coord(sx, cx, bx, 1'b0);
  assign py_s = walk_coord(sy, cy, by, 1'b0);
  assign px_d = walk_coord(dx, cx, bx, 1'b1);
  assign py_d = walk_coord(dy, cy, by, 1'b1);
  assign src_addr = {py_s[YB-1:0], px_s[XB-1:0]};
  assign dst_addr = {py_d[YB-1:0], px_d[XB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE; done <= 1'b1;
      sx <= '0; sy <= '0; dx <= '0; dy <= '0; w <= '0; h <= '0;
      cx <= '0; cy <= '0; bx <= 1'b0; by <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (launch && !zero_size) begin
          sx <= src_xy[15:0]; sy <= src_xy[31:16];
          dx <= dst_xy[15:0]; dy <= dst_xy[31:16];
          w  <= size_wh[15:0]; h <= size_wh[31:16];
          bx <= back_x; by <= back_y;
          cx <= '0; cy <= '0;
          done <= 1'b0;
          st <= W_READ;
        end
        W_READ: st <= W_WRITE;
        default: begin
          st <= W_READ;
          if (last_col) begin
            cx <= '0;
            if (last_row) begin
              st   <= W_IDLE;
              done <= 1'b1;
            end else cy <= cy + 16'd1;
          end else cx <= cx + 16'd1;
        end
      endcase
    end
  end

  // R6: each write follows the read of the same pixel, never back to back.
  assert_write_alternates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R8: done never reads 1 while a rectangle is still walked.
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: rtl/rop_frame_mem.sv
module rop_frame_mem
  import rect_rop_pkg::*;
#(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    src_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic             cap_en,
  input  logic             wr_en,
  input  logic [7:0]       rop_code,
  input  logic [PIX_W-1:0] plane_mask,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data
);
  logic [PIX_W-1:0] mem [DEPTH];
  logic [PIX_W-1:0] cap_src, cap_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cap_src <= '0;
      cap_dst <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= mem[rd_addr];
      if (cap_en) begin
        cap_src <= mem[src_addr];
        cap_dst <= mem[dst_addr];
      end
      if (wr_en) mem[dst_addr] <= rop_apply(rop_code, plane_mask, cap_src, cap_dst);
    end
  end

  // R5: after a write, the bits outside the mask still equal the captured old value.
  assert_mask_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((mem[$past(dst_addr)] ^ $past(cap_dst)) & ~$past(plane_mask)) == '0));
endmodule

// File: rtl/rect_rop_engine.sv
module rect_rop_engine
  import rect_rop_pkg::*;
#(
  parameter int FB_W = 16,
  parameter int FB_H = 16,
  localparam int AW = $clog2(FB_W) + $clog2(FB_H)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_word,
  output logic             cmd_ready,
  output logic [31:0]      status_word,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data
);
  logic             launch, back_x, back_y, busy, done, cap_en, wr_en;
  logic [7:0]       rop_code;
  logic [PIX_W-1:0] plane_mask;
  logic [31:0]      dst_xy, size_wh, src_xy;
  logic [AW-1:0]    src_addr, dst_addr;
  logic             zero_launch;

  assign status_word = {29'd0, done, 2'b00};
  assign zero_launch = launch && ((cmd_word[15:0] == 16'd0) || (size_wh[15:0] == 16'd0)
                                  || (size_wh[31:16] == 16'd0)) && (size_wh[15:0] == 16'd0
                                  || size_wh[31:16] == 16'd0);

  rop_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .engine_busy(busy), .cmd_ready(cmd_ready), .launch(launch),
    .rop_code(rop_code), .plane_mask(plane_mask), .back_x(back_x),
    .back_y(back_y), .dst_xy(dst_xy), .size_wh(size_wh), .src_xy(src_xy));

  rop_walker #(.FB_W(FB_W), .FB_H(FB_H)) u_walk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .back_x(back_x),
    .back_y(back_y), .dst_xy(dst_xy), .size_wh(size_wh), .src_xy(src_xy),
    .busy(busy), .done(done), .cap_en(cap_en), .wr_en(wr_en),
    .src_addr(src_addr), .dst_addr(dst_addr));

  rop_frame_mem #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .dst_addr(dst_addr),
    .cap_en(cap_en), .wr_en(wr_en), .rop_code(rop_code),
    .plane_mask(plane_mask), .rd_addr(rd_addr), .rd_data(rd_data));

  // R10: no rectangle is launched while one is being walked.
  assert_no_launch_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
  // R8: done only falls right after a launch.
  assert_done_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(launch));
  // R8: done only rises after a final write.
  assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en));
  // R9: an empty rectangle leaves the engine idle and done.
  assert_empty_rect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_launch |=> (done && !busy));
endmodule

// File: tb/tb_rect_rop_engine.sv
module tb_rect_rop_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_ready;
  logic [31:0] status_word;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit pend = 0;
  logic [7:0] model [NPIX];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  rect_rop_engine dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .cmd_ready(cmd_ready), .status_word(status_word),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares the read data against queued expectations.
  always @(posedge clk) begin
    #1;
    if (pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data === e, t, int'(rd_data), int'(e));
    end
  end

  // Independent model of one pixel operation, bit by bit.
  function automatic logic [7:0] model_op(input logic [7:0] code, input logic [7:0] m,
      input logic [7:0] s, input logic [7:0] d);
    logic [7:0] r;
    r = d;
    if (code == 8'h00 || code == 8'h33 || code == 8'hCC || code == 8'hFF)
      for (int b = 0; b < 8; b++)
        if (m[b]) begin
          if (code == 8'h00) r[b] = 1'b0;
          else if (code == 8'hFF) r[b] = 1'b1;
          else if (code == 8'hCC) r[b] = ~d[b];
          else r[b] = s[b];
        end
    return r;
  endfunction

  task automatic send(input logic [31:0] w);
    cmd_word = w;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic verify_frame(input string tag);
    for (int a = 0; a < NPIX; a++) begin
      @(negedge clk);
      rd_addr = a[7:0];
      pend = 1'b1;
      exp_q.push_back(model[a]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    pend = 1'b0;
    @(negedge clk);
  endtask

  // Launch a logical rectangle; the bench works out flags and corner words.
  task automatic rect_go(input logic [7:0] code, input logic [7:0] m, input bit cfg,
      input int sx, input int sy, input int dx, input int dy, input int w, input int h,
      input string tag);
    logic [7:0] snap [NPIX];
    bit bx, by;
    logic [15:0] wdx, wdy, wsx, wsy;
    if (cfg) begin
      send({4'h1, 4'h0, code, 16'h0000});
      send({4'h2, 20'h00000, m});
    end
    by = (sy < dy);
    bx = (sx < dx);
    wdx = 16'(bx ? dx + w : dx);
    wdy = 16'(by ? dy + h : dy);
    wsx = 16'(bx ? sx + w - 1 : sx);
    wsy = 16'(by ? sy + h - 1 : sy);
    send(32'h33f01000 | {28'd0, (by ? 4'hA : 4'h0) | (bx ? 4'h5 : 4'h0)});
    send({wdy, wdx});
    send({16'(h), 16'(w)});
    send({wsy, wsx});
    if (w != 0 && h != 0) begin
      check(status_word[2] == 1'b0, {tag, " R8 done low after launch"}, int'(status_word[2]), 0);
      check(cmd_ready == 1'b0, {tag, " R10 ready low while walking"}, int'(cmd_ready), 0);
    end else begin
      check(status_word[2] == 1'b1, {tag, " R9 empty rect keeps done"}, int'(status_word[2]), 1);
    end
    for (int a = 0; a < NPIX; a++) snap[a] = model[a];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) begin
        int s_a, d_a;
        s_a = (sy + j) * 16 + (sx + i);
        d_a = (dy + j) * 16 + (dx + i);
        model[d_a] = model_op(code, m, snap[s_a], snap[d_a]);
      end
  endtask

  task automatic rect_end(input string tag);
    while (!status_word[2]) @(negedge clk);
    check(cmd_ready == 1'b1, {tag, " R8 ready back with done"}, int'(cmd_ready), 1);
    verify_frame(tag);
  endtask

  task automatic rect(input logic [7:0] code, input logic [7:0] m, input bit cfg,
      input int sx, input int sy, input int dx, input int dy, input int w, input int h,
      input string tag);
    rect_go(code, m, cfg, sx, sy, dx, dy, w, h, tag);
    rect_end(tag);
  endtask

  task automatic fill(input int x, input int y, input int w, input int h,
      input logic [7:0] colour, input logic [7:0] planes, input string tag);
    if ((colour & planes) != 8'h00) rect(8'hFF, colour & planes, 1'b1, x, y, x, y, w, h, tag);
    if ((~colour & planes) != 8'h00) rect(8'h00, ~colour & planes, 1'b1, x, y, x, y, w, h, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NPIX; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_word[2] == 1'b1, "R1 done after reset", int'(status_word[2]), 1);
    check(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
    verify_frame("R1 frame zero after reset");

    fill(2, 1, 6, 4, 8'h5A, 8'hFF, "R4 R5 R6 two-pass fill");
    fill(4, 3, 5, 5, 8'h3C, 8'h0F, "R5 fill limited to low planes");
    rect(8'hCC, 8'hF0, 1'b1, 0, 0, 0, 0, 3, 2, "R4 invert masked bits");
    rect(8'h33, 8'hFF, 1'b1, 2, 1, 9, 8, 6, 5, "R3 R6 forward copy");
    rect(8'h33, 8'hFF, 1'b1, 2, 1, 4, 3, 6, 5, "R7 overlap copy backward X and Y");
    rect(8'h33, 8'hFF, 1'b1, 5, 5, 3, 4, 6, 6, "R6 overlap copy forward");
    rect(8'h33, 8'hFF, 1'b1, 1, 2, 1, 5, 10, 6, "R7 backward Y only");
    rect(8'h33, 8'hFF, 1'b1, 0, 10, 3, 10, 8, 3, "R7 backward X only");
    rect(8'h33, 8'h0F, 1'b1, 9, 8, 0, 12, 6, 3, "R5 copy low planes only");
    rect(8'h5A, 8'hFF, 1'b1, 2, 1, 8, 0, 4, 4, "R4 unknown code keeps dest");
    rect(8'hFF, 8'hFF, 1'b1, 0, 0, 0, 0, 0, 5, "R9 zero width");
    rect(8'hFF, 8'hFF, 1'b1, 0, 0, 0, 0, 4, 0, "R9 zero height");

    // R2: a mask word takes effect, an unknown tag is ignored.
    send({4'h2, 20'h00000, 8'h81});
    send(32'h5000_00FF);
    check(status_word[2] == 1'b1, "R2 unknown tag starts nothing", int'(status_word[2]), 1);
    rect(8'hFF, 8'h81, 1'b0, 12, 0, 12, 0, 4, 4, "R2 latched mask reused");

    // R10: a word offered while busy must not replace the ROP code.
    rect_go(8'hFF, 8'h80, 1'b1, 8, 8, 8, 8, 8, 8, "R10 long set pass");
    cmd_word = {4'h1, 4'h0, 8'hCC, 16'h0000};
    cmd_valid = 1'b1;
    repeat (6) @(negedge clk);
    check(cmd_ready == 1'b0, "R10 ready held low", int'(cmd_ready), 0);
    cmd_valid = 1'b0;
    rect_end("R10 long set pass");
    rect(8'hFF, 8'h80, 1'b0, 0, 8, 0, 8, 4, 4, "R10 held word not taken");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule